// File: doc/BRIEF.md
# Synchronous Serial Master Port

This block is a memory-mapped serial master for a four-wire peripheral bus. Software reaches it through a small 32-bit register interface: an address, a write strobe with write data, and a read strobe with combinational read data. It drives the serial clock and the outgoing data line, and it samples the incoming data line. Chip selects are not generated here, because general-purpose pins outside the block provide them.

Software sets the frame width, the clock polarity, the clock phase and a two-stage clock divider. It then writes frames into an eight-entry transmit queue. The serial engine sends each frame most significant bit first and places the word it receives in an eight-entry receive queue. Reading the data register takes that word out.

Three interrupt causes are each masked by their own enable bit and then combined onto one interrupt line: the receive queue at or above half full, the transmit queue at or below half full, and receive overrun. A loopback mode feeds the transmitted bits straight back into the receiver.

Top module: `spi_sync_port`

## Requirements
- R1: After reset, control word A (offset 0x00), control word B (0x04) and the prescaler (0x10) read 0, status (0x0C) reads 0x03, the interrupt word (0x14) reads 0, `irq` is 0 and `sclk` is 0.
- R2: Control word A holds the frame size minus one in bits 3:0, where values 3 to 15 give 4 to 16 bits and values below 3 give 4 bits. Bit 6 is polarity, bit 7 is phase, and bits 15:8 are the rate divider SCR. A transmitted frame carries exactly that many bits.
- R3: One `sclk` period lasts CPSR×(1+SCR) clock cycles. CPSR is the prescaler value with bit 0 ignored, and 0 acts as 2.
- R4: Frames leave on `mosi` most significant bit first, in the order they were written to the data register (0x08).
- R5: `sclk` rests at the polarity bit. With phase 0, both sides sample data on the first edge of each bit; with phase 1, they sample on the second edge. The received frame comes from `miso` sampled at those edges.
- R6: Each queue holds 8 frames. A data write while the transmit queue is full is dropped, and a data read while the receive queue is empty returns 0 and changes nothing.
- R7: Status bit 0 means the transmit queue is empty, bit 1 that it is not full, bit 2 that the receive queue is not empty, bit 3 that the receive queue is full, and bit 4 that the port is busy (shifting, or with frames still queued).
- R8: If a frame completes while the receive queue is full, the frame is discarded and an overrun flag is set. The flag stays set until any write to 0x14.
- R9: The interrupt word reports bit 0 (receive queue holds 4 or more frames), bit 1 (transmit queue holds 4 or fewer frames) and bit 2 (overrun). Each bit is ANDed with its enable in control word B, bits 0, 1 and 2, and `irq` is the OR of the three.
- R10: When loopback (control word B bit 3) is set, `mosi` stays 0 and the receiver takes the transmitted bits, so the word read back equals the word written.
- R11: While port enable (control word B bit 4) is clear, no frame starts and queued frames wait. Clearing it in the middle of a frame ends the frame at once with `sclk` back at rest, and nothing is received.
- R12: A read of the data register returns the oldest received frame, zero-extended, and removes it from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops the receive queue at the data offset) |
| bus_rdata | output | 32 | Combinational read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench runs all four polarity and phase pairings at 4, 8, 12 and 16 bits. It checks every sampled `mosi` bit and every word received from a bench slave. A design that samples on the wrong edge would return shifted or rotated words, and one that sends least significant bit first would fail on the asymmetric patterns. The divider is timed at two settings, one of them with an odd prescaler, so treating bit 0 of the prescaler as significant or dropping the (1+SCR) factor shows up as a wrong period.

The bench drives the edges of both queues: a ninth write into a full transmit queue, and a ninth frame arriving at a full receive queue. It then checks that the overrun flag stays set after reads and clears only on a write to 0x14. It also disables the port in the middle of a frame and checks that `sclk` returns to rest and that no word reaches the receive queue.

// File: rtl/smp_pkg.sv
`timescale 1ns/1ps
package smp_pkg;
  localparam int unsigned OFS_CTRL_A = 32'h00;
  localparam int unsigned OFS_CTRL_B = 32'h04;
  localparam int unsigned OFS_DATA   = 32'h08;
  localparam int unsigned OFS_STAT   = 32'h0C;
  localparam int unsigned OFS_PRESC  = 32'h10;
  localparam int unsigned OFS_INTR   = 32'h14;

  localparam int unsigned MIN_SIZE_M1 = 3;

  typedef enum logic {ENG_IDLE = 1'b0, ENG_SHIFT = 1'b1} eng_state_e;
endpackage

// File: rtl/smp_fifo.sv
`timescale 1ns/1ps
module smp_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DATA_W-1:0]            din,
  input  logic                         pop,
  output logic [DATA_W-1:0]            dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr_n, rd_ptr_n;
  logic [CNT_W-1:0]  cnt_n;
  logic              do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_n    = count;
    if (do_push) wr_ptr_n = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_n = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
    if (do_push && !do_pop)      cnt_n = count + 1'b1;
    else if (do_pop && !do_push) cnt_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      count  <= cnt_n;
    end
  end

  // storage without reset: contents are only observed behind count
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/smp_rate_gen.sv
`timescale 1ns/1ps
module smp_rate_gen #(
  parameter int PRE_W = 7,
  parameter int SCR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre_half,
  input  logic [SCR_W-1:0] scr,
  output logic             half_tick
);
  logic [PRE_W-1:0] pre_cnt, pre_cnt_n, pre_lim;
  logic [SCR_W-1:0] scr_cnt, scr_cnt_n;
  logic             pre_wrap, scr_wrap;

  // a zero prescaler acts as the smallest legal value
  assign pre_lim   = (pre_half == '0) ? '0 : pre_half - 1'b1;
  assign pre_wrap  = (pre_cnt == pre_lim);
  assign scr_wrap  = (scr_cnt == scr);
  assign half_tick = run && pre_wrap && scr_wrap;

  always_comb begin
    pre_cnt_n = pre_cnt;
    scr_cnt_n = scr_cnt;
    if (!run) begin
      pre_cnt_n = '0;
      scr_cnt_n = '0;
    end else if (pre_wrap) begin
      pre_cnt_n = '0;
      scr_cnt_n = scr_wrap ? '0 : scr_cnt + 1'b1;
    end else begin
      pre_cnt_n = pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      scr_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt_n;
      scr_cnt <= scr_cnt_n;
    end
  end
endmodule

// File: rtl/smp_engine.sv
`timescale 1ns/1ps
module smp_engine
  import smp_pkg::*;
#(
  parameter int FRAME_W = 16,
  localparam int BIT_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_en,
  input  logic               cpol,
  input  logic               cpha,
  input  logic               loop_en,
  input  logic [BIT_W-1:0]   size_m1,
  input  logic               half_tick,
  input  logic               tx_empty,
  input  logic [FRAME_W-1:0] tx_data,
  input  logic               rx_full,
  input  logic               miso,
  output logic               tx_pop,
  output logic               rx_push,
  output logic [FRAME_W-1:0] rx_data,
  output logic               overrun_set,
  output logic               run,
  output logic               sclk,
  output logic               mosi
);
  eng_state_e         st, st_n;
  logic [FRAME_W-1:0] tx_word, tx_word_n, rx_sr, rx_sr_n, rx_shifted;
  logic [BIT_W-1:0]   bit_k, bit_k_n;
  logic               lead, lead_n, sclk_n, mosi_q, mosi_n, din, frame_done;

  assign din        = loop_en ? mosi_q : miso;
  assign rx_shifted = {rx_sr[FRAME_W-2:0], din};
  assign run        = (st == ENG_SHIFT);
  assign mosi       = loop_en ? 1'b0 : mosi_q;

  always_comb begin
    st_n       = st;
    tx_word_n  = tx_word;
    rx_sr_n    = rx_sr;
    bit_k_n    = bit_k;
    lead_n     = lead;
    sclk_n     = sclk;
    mosi_n     = mosi_q;
    tx_pop     = 1'b0;
    frame_done = 1'b0;
    if (st == ENG_IDLE) begin
      sclk_n = cpol;
      if (port_en && !tx_empty) begin
        tx_pop    = 1'b1;
        st_n      = ENG_SHIFT;
        tx_word_n = tx_data;
        rx_sr_n   = '0;
        bit_k_n   = size_m1;
        lead_n    = 1'b1;
        if (!cpha) mosi_n = tx_data[size_m1];
      end
    end else if (!port_en) begin
      st_n   = ENG_IDLE;
      sclk_n = cpol;
    end else if (half_tick) begin
      if (lead) begin
        sclk_n = !cpol;
        lead_n = 1'b0;
        if (!cpha) rx_sr_n = rx_shifted;
        else       mosi_n  = tx_word[bit_k];
      end else begin
        sclk_n = cpol;
        lead_n = 1'b1;
        if (cpha)               rx_sr_n = rx_shifted;
        else if (bit_k != '0)   mosi_n  = tx_word[bit_k - 1'b1];
        if (bit_k == '0) begin
          st_n       = ENG_IDLE;
          frame_done = 1'b1;
        end else begin
          bit_k_n = bit_k - 1'b1;
        end
      end
    end
  end

  assign rx_data     = cpha ? rx_shifted : rx_sr;
  assign rx_push     = frame_done && !rx_full;
  assign overrun_set = frame_done && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ENG_IDLE;
      tx_word <= '0;
      rx_sr   <= '0;
      bit_k   <= '0;
      lead    <= 1'b1;
      sclk    <= 1'b0;
      mosi_q  <= 1'b0;
    end else begin
      st      <= st_n;
      tx_word <= tx_word_n;
      rx_sr   <= rx_sr_n;
      bit_k   <= bit_k_n;
      lead    <= lead_n;
      sclk    <= sclk_n;
      mosi_q  <= mosi_n;
    end
  end
endmodule

// File: rtl/spi_sync_port.sv
`timescale 1ns/1ps
module spi_sync_port
  import smp_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int FRAME_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              irq
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH+1);
  localparam int BIT_W  = $clog2(FRAME_W);
  localparam int HALF_Q = FIFO_DEPTH / 2;

  // control word A
  logic [3:0] size_f;
  logic       cpol, cpha;
  logic [7:0] scr;
  // control word B
  logic [6:0] ctl_b;
  logic [7:0] presc;
  logic       ror_flag, ror_n;

  logic sel_a, sel_b, sel_data, sel_stat, sel_presc, sel_intr;
  logic wr_a, wr_b, wr_presc, tx_push, rx_pop, clr_hit;

  logic [FRAME_W-1:0] tx_dout, rx_din, rx_dout;
  logic [CNT_W-1:0]   tx_cnt, rx_cnt;
  logic               tx_full, tx_empty, rx_full, rx_empty;
  logic               tx_pop, rx_push, overrun_set, eng_run, half_tick;
  logic [BIT_W-1:0]   size_m1;
  logic [2:0]         intr_raw, intr_vec;
  logic               port_en, loop_en;

  assign sel_a     = (bus_addr == ADDR_W'(OFS_CTRL_A));
  assign sel_b     = (bus_addr == ADDR_W'(OFS_CTRL_B));
  assign sel_data  = (bus_addr == ADDR_W'(OFS_DATA));
  assign sel_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign sel_presc = (bus_addr == ADDR_W'(OFS_PRESC));
  assign sel_intr  = (bus_addr == ADDR_W'(OFS_INTR));

  assign wr_a     = bus_wr && sel_a;
  assign wr_b     = bus_wr && sel_b;
  assign wr_presc = bus_wr && sel_presc;
  assign tx_push  = bus_wr && sel_data;
  assign clr_hit  = bus_wr && sel_intr;
  assign rx_pop   = bus_rd && sel_data;

  assign port_en = ctl_b[4];
  assign loop_en = ctl_b[3];
  assign size_m1 = (size_f < 4'(MIN_SIZE_M1)) ? BIT_W'(MIN_SIZE_M1) : BIT_W'(size_f);

  // control registers with written-out clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_f <= '0;
      cpol   <= 1'b0;
      cpha   <= 1'b0;
      scr    <= '0;
    end else if (wr_a) begin
      size_f <= bus_wdata[3:0];
      cpol   <= bus_wdata[6];
      cpha   <= bus_wdata[7];
      scr    <= bus_wdata[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctl_b <= '0;
    else if (wr_b) ctl_b <= bus_wdata[6:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc <= '0;
    else if (wr_presc) presc <= bus_wdata[7:0];
  end

  // a new overrun in the same cycle as a clear wins
  always_comb begin
    ror_n = ror_flag;
    if (clr_hit)     ror_n = 1'b0;
    if (overrun_set) ror_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ror_flag <= 1'b0;
    else        ror_flag <= ror_n;
  end

  smp_fifo #(.DATA_W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[FRAME_W-1:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  smp_fifo #(.DATA_W(FRAME_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  smp_rate_gen #(.PRE_W(7), .SCR_W(8)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(eng_run), .pre_half(presc[7:1]),
    .scr(scr), .half_tick(half_tick)
  );

  smp_engine #(.FRAME_W(FRAME_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .cpol(cpol), .cpha(cpha),
    .loop_en(loop_en), .size_m1(size_m1), .half_tick(half_tick),
    .tx_empty(tx_empty), .tx_data(tx_dout), .rx_full(rx_full), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_din),
    .overrun_set(overrun_set), .run(eng_run), .sclk(sclk), .mosi(mosi)
  );

  assign intr_raw = {ror_flag, (tx_cnt <= CNT_W'(HALF_Q)), (rx_cnt >= CNT_W'(HALF_Q))};
  assign intr_vec = intr_raw & ctl_b[2:0];
  assign irq      = |intr_vec;

  always_comb begin
    bus_rdata = '0;
    if (sel_a) begin
      bus_rdata[3:0]  = size_f;
      bus_rdata[6]    = cpol;
      bus_rdata[7]    = cpha;
      bus_rdata[15:8] = scr;
    end else if (sel_b) begin
      bus_rdata[6:0] = ctl_b;
    end else if (sel_data) begin
      if (!rx_empty) bus_rdata[FRAME_W-1:0] = rx_dout;
    end else if (sel_stat) begin
      bus_rdata[4:0] = {eng_run || !tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};
    end else if (sel_presc) begin
      bus_rdata[7:0] = presc;
    end else if (sel_intr) begin
      bus_rdata[2:0] = intr_vec;
    end
  end
endmodule

// File: rtl/smp_checker.sv
`timescale 1ns/1ps
module smp_checker #(
  parameter int CNT_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             mosi,
  input logic             irq,
  input logic             cpol,
  input logic             loop_en,
  input logic             port_en,
  input logic             eng_run,
  input logic             half_tick,
  input logic             ror_flag,
  input logic             clr_hit,
  input logic [2:0]       ien,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);
  // R5: at rest the serial clock follows polarity
  p_sclk_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_run && !$past(eng_run) && ($past(cpol) == cpol)) |-> (sclk == cpol));

  // R3: the serial clock moves only on a divider tick
  p_sclk_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_run && port_en && !half_tick) |=> $stable(sclk));

  // R10: loopback keeps the outgoing line quiet
  p_loop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && $past(loop_en)) |-> !mosi);

  // R8: overrun is sticky until cleared
  p_ror_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ror_flag && !clr_hit) |=> ror_flag);

  // R9: no interrupt without an enable
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien != 3'b000));

  // R6: neither queue exceeds its depth
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

  // R11: a disabled port stops shifting
  p_idle_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en && !$past(port_en)) |-> !eng_run);
endmodule

bind spi_sync_port smp_checker #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .irq(irq), .cpol(cpol),
  .loop_en(loop_en), .port_en(port_en), .eng_run(eng_run), .half_tick(half_tick),
  .ror_flag(ror_flag), .clr_hit(clr_hit), .ien(ctl_b[2:0]),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_sync_port_bench.sv
`timescale 1ns/1ps
module spi_sync_port_bench;
  logic        clk, rst_n, bus_wr, bus_rd, miso;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sclk, mosi, irq;

  spi_sync_port u_spi_sync_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench-side mode, slave and monitor state
  int          tb_w = 8;
  bit          tb_cpol = 0, tb_cpha = 0, mon_on = 0;
  logic [15:0] sw = 16'h0;
  int          s_idx = 7;
  logic [15:0] mon_sr = 16'h0;
  int          mon_n = 0;
  logic [15:0] exp_q[$];

  function automatic logic [15:0] wmask(int w);
    return 16'((32'd1 << w) - 1);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic slave_shift();
    if (!tb_cpha) begin
      s_idx = (s_idx == 0) ? tb_w - 1 : s_idx - 1;
      miso  = sw[s_idx];
    end else begin
      miso  = sw[s_idx];
      s_idx = (s_idx == 0) ? tb_w - 1 : s_idx - 1;
    end
  endtask

  // scoreboard monitor: every sampled frame is compared with the queue head
  task automatic mon_bit();
    if (!mon_on) return;
    mon_sr = {mon_sr[14:0], mosi};
    mon_n++;
    if (mon_n == tb_w) begin
      mon_n = 0;
      if (exp_q.size() == 0) chk("R4 unexpected frame", mon_sr & wmask(tb_w), 32'hFFFF_FFFF);
      else chk("R4 R2 mosi frame", mon_sr & wmask(tb_w), exp_q.pop_front());
    end
  endtask

  always @(posedge sclk) if (tb_cpol != tb_cpha) slave_shift(); else mon_bit();
  always @(negedge sclk) if (tb_cpol == tb_cpha) slave_shift(); else mon_bit();

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic send(logic [15:0] v);
    exp_q.push_back(v & wmask(tb_w));
    bus_write(5'h08, {16'h0, v});
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(5'h0C, s);
      if (!s[4]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg(bit cp, bit ch, int w, int scr, int cpsr, logic [6:0] b);
    bus_write(5'h04, 32'h0);
    bus_write(5'h00, (scr << 8) | (ch << 7) | (cp << 6) | (w - 1));
    bus_write(5'h10, cpsr);
    repeat (3) @(negedge clk);
    tb_cpol = cp; tb_cpha = ch; tb_w = w;
    s_idx = w - 1; miso = sw[w - 1];
    mon_n = 0; mon_sr = '0;
    bus_write(5'h04, {25'h0, b});
  endtask

  task automatic read_expect(string req, logic [31:0] exp);
    logic [31:0] v;
    bus_read(5'h08, v);
    chk(req, v, exp);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    longint t0, t1;
    bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0; miso = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R7 reset state
    bus_read(5'h00, v); chk("R1 ctrl A reset", v, 0);
    bus_read(5'h04, v); chk("R1 ctrl B reset", v, 0);
    bus_read(5'h10, v); chk("R1 prescaler reset", v, 0);
    bus_read(5'h0C, v); chk("R1 R7 status reset", v, 32'h03);
    bus_read(5'h14, v); chk("R1 intr reset", v, 0);
    chk("R1 irq/sclk reset", {irq, sclk}, 0);

    // R2: control word A readback
    bus_write(5'h00, 32'h0000_2BC7);
    bus_read(5'h00, v); chk("R2 ctrl A fields", v, 32'h2BC7);

    // R4 R5 R12: mode 0, 8 bits, fastest clock
    sw = 16'h00B2;
    cfg(0, 0, 8, 0, 2, 7'h10);
    mon_on = 1;
    send(16'h00A5); send(16'h003C); send(16'h0081);
    wait_idle();
    chk("R4 all frames seen", exp_q.size(), 0);
    for (int i = 0; i < 3; i++) read_expect("R5 R12 rx mode0", 32'hB2);
    bus_read(5'h0C, v); chk("R7 status after drain", v, 32'h03);

    // R5 R2: remaining modes and widths
    sw = 16'h0A53;
    cfg(0, 1, 12, 0, 2, 7'h10);
    send(16'h0C71); send(16'h0F0E);
    wait_idle();
    for (int i = 0; i < 2; i++) read_expect("R5 rx mode1 w12", 32'h0A53);
    sw = 16'hC3A9;
    cfg(1, 0, 16, 1, 2, 7'h10);
    send(16'h8001); send(16'h7E5A);
    wait_idle();
    for (int i = 0; i < 2; i++) read_expect("R5 rx mode2 w16", 32'hC3A9);
    sw = 16'h0009;
    cfg(1, 1, 4, 0, 2, 7'h10);
    chk("R5 sclk rest high", sclk, 1);
    send(16'h0006); send(16'hFFF3);
    wait_idle();
    for (int i = 0; i < 2; i++) read_expect("R5 rx mode3 w4", 32'h9);
    chk("R2 R4 queue empty", exp_q.size(), 0);

    // R2: size field below 3 behaves as 4 bits
    sw = 16'h0005;
    cfg(0, 0, 4, 0, 2, 7'h10);
    bus_write(5'h00, 32'h0000_0001);
    send(16'h000D);
    wait_idle();
    read_expect("R2 small size as 4 bits", 32'h5);

    // R3: period measurement
    sw = 16'h0055;
    cfg(0, 0, 8, 2, 4, 7'h10);
    send(16'h0033);
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    chk("R3 period cpsr4 scr2", (t1 - t0) / 4, 12);
    wait_idle(); read_expect("R3 rx", 32'h55);
    cfg(0, 0, 8, 0, 5, 7'h10);
    send(16'h0071);
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    chk("R3 period odd cpsr", (t1 - t0) / 4, 4);
    wait_idle(); read_expect("R3 rx odd", 32'h55);

    // R8 R9 R6: receive overrun with interrupts
    sw = 16'h00E4;
    cfg(0, 0, 8, 0, 2, 7'h15);
    for (int i = 0; i < 9; i++) send(16'(i * 17 + 3));
    wait_idle();
    bus_read(5'h14, v); chk("R8 R9 overrun and rx intr", v, 32'h5);
    chk("R9 irq high", irq, 1);
    for (int i = 0; i < 5; i++) read_expect("R12 rx after overrun", 32'hE4);
    bus_read(5'h14, v); chk("R8 sticky after reads", v, 32'h4);
    bus_write(5'h14, 32'h0);
    bus_read(5'h14, v); chk("R8 cleared", v, 0);
    chk("R9 irq low", irq, 0);
    for (int i = 0; i < 3; i++) read_expect("R8 eight kept", 32'hE4);
    read_expect("R6 empty read", 0);

    // R9 transmit level and R11 hold while disabled
    cfg(0, 0, 8, 0, 2, 7'h02);
    bus_read(5'h14, v); chk("R9 tx intr empty", v, 32'h2);
    for (int i = 0; i < 4; i++) send(16'(8'h40 + i));
    bus_read(5'h14, v); chk("R9 tx intr at half", v, 32'h2);
    send(16'h0044);
    bus_read(5'h14, v); chk("R9 tx intr above half", v, 0);
    repeat (40) @(negedge clk);
    bus_read(5'h0C, v); chk("R11 held while disabled", v, 32'h12);
    chk("R11 sclk rest", sclk, 0);
    bus_write(5'h04, 32'h12);
    wait_idle();
    bus_read(5'h14, v); chk("R9 tx intr after drain", v, 32'h2);
    for (int i = 0; i < 5; i++) read_expect("R11 rx after enable", 32'hE4);

    // R6: transmit queue overflow drops writes
    cfg(0, 0, 8, 0, 2, 7'h00);
    for (int i = 0; i < 10; i++) begin
      if (i < 8) exp_q.push_back(16'(8'h90 + i));
      bus_write(5'h08, 32'h90 + i);
    end
    bus_read(5'h0C, v); chk("R6 R7 tx full status", v, 32'h10);
    bus_write(5'h04, 32'h10);
    wait_idle();
    chk("R6 only eight sent", exp_q.size(), 0);
    bus_read(5'h0C, v); chk("R7 rx full status", v, 32'h0F);
    for (int i = 0; i < 8; i++) read_expect("R6 rx", 32'hE4);

    // R11: abort mid-frame
    mon_on = 0;
    cfg(0, 0, 8, 3, 8, 7'h10);
    bus_write(5'h08, 32'h5A);
    repeat (40) @(negedge clk);
    bus_write(5'h04, 32'h0);
    repeat (3) @(negedge clk);
    chk("R11 sclk rest after abort", sclk, 0);
    bus_read(5'h0C, v); chk("R11 idle no rx", v, 32'h03);

    // R10: loopback in mode 3, 16 bits
    cfg(1, 1, 16, 0, 2, 7'h18);
    bus_write(5'h08, 32'h1234);
    bus_write(5'h08, 32'hBEEF);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R10 mosi quiet", mosi, 0);
    end
    wait_idle();
    read_expect("R10 loop word 1", 32'h1234);
    read_expect("R10 loop word 2", 32'hBEEF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule